// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This block gives each hart of a small multi-hart cluster a machine timer interrupt and a machine software interrupt. One free-running 64-bit time counter is shared by all harts. It advances by one on every cycle in which the timebase tick enable input is high. Each hart also owns a 64-bit compare register and a one-bit software-interrupt flag. A hart's timer line is high while its compare value is at or below the counter, so software sets the next deadline by writing that hart's compare register.

Software reaches the block through a 32-bit request port. The port carries a byte offset, a write flag and write data. A read returns its data on the following cycle, marked by a response-valid pulse. The 64-bit registers are split into low and high words. A write to one half keeps the other half. The counter cannot be written. Reading its low word captures the high word, so a later high-word read gives a consistent 64-bit value. The hart count and the base offsets of the three register regions are parameters.

Top module: `core_timer_unit`

## Requirements
- R1: The time counter resets to 0 and increases by exactly one on each clock cycle in which `tick_en` is high. It holds its value otherwise.
- R2: A read at `TIME_BASE` returns counter bits 31:0 and captures counter bits 63:32. A read at `TIME_BASE+4` returns the bits captured by the most recent low-word read, or 0 if no low-word read has happened since reset. Writes to either offset leave the counter unchanged.
- R3: The software-interrupt region starting at `SWI_BASE` holds one 4-byte slot per hart, at offset `4*h` for hart h. A write stores bit 0 of the write data and drives `soft_irq[h]` with it. A read returns that bit in bit 0, with every other bit 0.
- R4: The compare region starting at `CMP_BASE` holds one 8-byte slot per hart, at offset `8*h` for hart h. Slot offset 0 is compare bits 31:0 and slot offset 4 is bits 63:32. Writing either word replaces only that half. Reading either word returns that half.
- R5: `timer_irq[h]` is registered and equals the result of the unsigned test compare(h) <= counter, taken from the register values of the previous cycle. A change of the counter or of a compare value therefore appears on the line one cycle later.
- R6: Reset sets every compare register, every software-interrupt flag and every output to 0.
- R7: A read of an offset outside the mapped slots, or of a mapped slot at an offset it does not decode, returns 0. A write there changes no register. This covers offsets past the last hart and offsets that are not a multiple of 4.
- R8: `rsp_valid` is high in the cycle after each accepted read, and `rsp_rdata` carries the read data in that cycle. `rsp_valid` is low after a write and after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick; the counter increments in cycles where it is high |
| req_valid | input | 1 | Request strobe for one access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| timer_irq | output | NUM_HARTS | Machine timer interrupt, one per hart |
| soft_irq | output | NUM_HARTS | Machine software interrupt, one per hart |

## Verification
The properties assume that `tick_en` is a clean synchronous level, and that a request lasts exactly one cycle with `req_write` and `req_addr` stable while `req_valid` is high. The bench meets this by driving every input on the falling edge and dropping `req_valid` after a single cycle. It holds `tick_en` low during register accesses, except where a test deliberately makes the counter cross a compare value. Counter high-word coherence is exercised only near zero, because the bench cannot run the counter through 2^32 ticks.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
    localparam int CNT_W  = 64;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SWI,
        RG_CMP_LO,
        RG_CMP_HI,
        RG_TIME_LO,
        RG_TIME_HI
    } region_e;
endpackage

// File: rtl/ctu_decoder.sv
module ctu_decoder
    import ctu_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_HARTS = 2,
    parameter int SWI_BASE  = 'h0000,
    parameter int CMP_BASE  = 'h4000,
    parameter int TIME_BASE = 'hBFF8,
    localparam int HIDX_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [HIDX_W-1:0] hart
);
    localparam logic [ADDR_W-1:0] SWI_B    = ADDR_W'(SWI_BASE);
    localparam logic [ADDR_W-1:0] CMP_B    = ADDR_W'(CMP_BASE);
    localparam logic [ADDR_W-1:0] TIME_B   = ADDR_W'(TIME_BASE);
    localparam logic [ADDR_W-1:0] TIME_B4  = ADDR_W'(TIME_BASE + 4);
    localparam logic [ADDR_W-1:0] SWI_SPAN = ADDR_W'(4 * NUM_HARTS);
    localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(8 * NUM_HARTS);

    logic [ADDR_W-1:0] swi_off;
    logic [ADDR_W-1:0] cmp_off;
    logic              in_swi;
    logic              in_cmp;

    always_comb begin
        swi_off = addr - SWI_B;
        cmp_off = addr - CMP_B;
        in_swi  = (addr >= SWI_B) && (swi_off < SWI_SPAN);
        in_cmp  = (addr >= CMP_B) && (cmp_off < CMP_SPAN);
        region  = RG_NONE;
        hart    = '0;
        if (in_swi) begin
            hart = swi_off[HIDX_W+1:2];
            if (swi_off[1:0] == 2'b00) region = RG_SWI;
        end else if (in_cmp) begin
            hart = cmp_off[HIDX_W+2:3];
            if (cmp_off[2:0] == 3'd0)      region = RG_CMP_LO;
            else if (cmp_off[2:0] == 3'd4) region = RG_CMP_HI;
        end else if (addr == TIME_B) begin
            region = RG_TIME_LO;
        end else if (addr == TIME_B4) begin
            region = RG_TIME_HI;
        end
    end
endmodule

// File: rtl/ctu_counter.sv
module ctu_counter
    import ctu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              snap_en,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] snap_hi
);
    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [DATA_W-1:0] snap_hi;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_en) st_d.count = st_q.count + 1'b1;
        // capture the upper half together with the low-word read
        if (snap_en) st_d.snap_hi = st_q.count[CNT_W-1:DATA_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.count;
    assign snap_hi = st_q.snap_hi;
endmodule

// File: rtl/ctu_hart_slot.sv
module ctu_hart_slot
    import ctu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic              we_swi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp,
    output logic              swi,
    output logic              tirq
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             swi;
        logic             tirq;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_lo)  st_d.cmp[DATA_W-1:0]     = wdata;
        if (we_hi)  st_d.cmp[CNT_W-1:DATA_W] = wdata;
        if (we_swi) st_d.swi                 = wdata[0];
        // registered level from present register contents
        st_d.tirq = (st_q.cmp <= count);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp  = st_q.cmp;
    assign swi  = st_q.swi;
    assign tirq = st_q.tirq;
endmodule

// File: rtl/core_timer_unit.sv
module core_timer_unit
    import ctu_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_HARTS = 2,
    parameter int SWI_BASE  = 'h0000,
    parameter int CMP_BASE  = 'h4000,
    parameter int TIME_BASE = 'hBFF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic [NUM_HARTS-1:0] timer_irq,
    output logic [NUM_HARTS-1:0] soft_irq
);
    localparam int HIDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_state_t;

    region_e                          region;
    logic [HIDX_W-1:0]                hart;
    logic [CNT_W-1:0]                 count_w;
    logic [DATA_W-1:0]                snap_hi;
    logic [NUM_HARTS-1:0][CNT_W-1:0]  cmp_all;
    logic                             rd_req;
    logic                             wr_req;
    logic                             snap_en;
    logic [DATA_W-1:0]                rd_data;
    rsp_state_t                       rsp_d, rsp_q;

    assign rd_req  = req_valid && !req_write;
    assign wr_req  = req_valid && req_write;
    assign snap_en = rd_req && (region == RG_TIME_LO);

    ctu_decoder #(
        .ADDR_W    (ADDR_W),
        .NUM_HARTS (NUM_HARTS),
        .SWI_BASE  (SWI_BASE),
        .CMP_BASE  (CMP_BASE),
        .TIME_BASE (TIME_BASE)
    ) u_dec (
        .addr   (req_addr),
        .region (region),
        .hart   (hart)
    );

    ctu_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .snap_en (snap_en),
        .count   (count_w),
        .snap_hi (snap_hi)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic sel;
        assign sel = wr_req && (hart == HIDX_W'(h));
        ctu_hart_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .count  (count_w),
            .we_lo  (sel && (region == RG_CMP_LO)),
            .we_hi  (sel && (region == RG_CMP_HI)),
            .we_swi (sel && (region == RG_SWI)),
            .wdata  (req_wdata),
            .cmp    (cmp_all[h]),
            .swi    (soft_irq[h]),
            .tirq   (timer_irq[h])
        );
    end

    always_comb begin
        rd_data = '0;
        unique case (region)
            RG_TIME_LO: rd_data = count_w[DATA_W-1:0];
            RG_TIME_HI: rd_data = snap_hi;
            RG_SWI, RG_CMP_LO, RG_CMP_HI: begin
                for (int h = 0; h < NUM_HARTS; h++) begin
                    if (hart == HIDX_W'(h)) begin
                        if (region == RG_SWI)
                            rd_data = {{(DATA_W-1){1'b0}}, soft_irq[h]};
                        else if (region == RG_CMP_LO)
                            rd_data = cmp_all[h][DATA_W-1:0];
                        else
                            rd_data = cmp_all[h][CNT_W-1:DATA_W];
                    end
                end
            end
            default: rd_data = '0;
        endcase
    end

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = rd_req;
        if (rd_req) rsp_d.data = rd_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;
endmodule

// File: rtl/ctu_checker.sv
module ctu_checker #(
    parameter int NUM_HARTS = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick_en,
    input logic                        req_valid,
    input logic                        req_write,
    input logic                        rsp_valid,
    input logic [63:0]                 count_w,
    input logic [NUM_HARTS-1:0][63:0]  cmp_all,
    input logic [NUM_HARTS-1:0]        timer_irq,
    input logic [NUM_HARTS-1:0]        soft_irq
);
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count_w == $past(count_w) + 64'd1);

    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count_w));

    // R3: software flags move only on a write request
    assert_swi_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(soft_irq));

    assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_chk
        assert_timer_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> timer_irq[h] == ($past(cmp_all[h]) <= $past(count_w)));
    end
endmodule

bind core_timer_unit ctu_checker #(.NUM_HARTS(NUM_HARTS)) u_ctu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .count_w   (count_w),
    .cmp_all   (cmp_all),
    .timer_irq (timer_irq),
    .soft_irq  (soft_irq)
);

// File: tb/tb_core_timer_unit.sv
module tb_core_timer_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int NH         = 2;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h4000, 32'h0,        32'h0},         // R6 cmp0 lo reset
        '{1'b0, 16'h4004, 32'h0,        32'h0},         // R6 cmp0 hi reset
        '{1'b0, 16'h0000, 32'h0,        32'h0},         // R6 swi0 reset
        '{1'b1, 16'h4008, 32'h11112222, 32'h0},         // R4 cmp1 lo
        '{1'b1, 16'h400C, 32'h33334444, 32'h0},         // R4 cmp1 hi
        '{1'b0, 16'h4008, 32'h0,        32'h11112222},  // R4
        '{1'b0, 16'h400C, 32'h0,        32'h33334444},  // R4
        '{1'b1, 16'h4008, 32'hAAAA5555, 32'h0},         // R4 lo merge
        '{1'b0, 16'h400C, 32'h0,        32'h33334444},  // R4 hi kept
        '{1'b0, 16'h4008, 32'h0,        32'hAAAA5555},  // R4
        '{1'b1, 16'h0004, 32'hFFFFFFFE, 32'h0},         // R3 bit0 only
        '{1'b0, 16'h0004, 32'h0,        32'h0},         // R3
        '{1'b1, 16'h0004, 32'h00000003, 32'h0},         // R3
        '{1'b0, 16'h0004, 32'h0,        32'h1},         // R3
        '{1'b0, 16'h0000, 32'h0,        32'h0},         // R3 other hart
        '{1'b0, 16'h0006, 32'h0,        32'h0},         // R7 misaligned read
        '{1'b1, 16'h0002, 32'h1,        32'h0},         // R7 misaligned write
        '{1'b0, 16'h0000, 32'h0,        32'h0},         // R7
        '{1'b1, 16'h4001, 32'h5,        32'h0},         // R7
        '{1'b0, 16'h4000, 32'h0,        32'h0},         // R7
        '{1'b1, 16'h4010, 32'h7,        32'h0},         // R7 past last hart
        '{1'b0, 16'h0008, 32'h0,        32'h0},         // R7 past last hart
        '{1'b1, 16'hBFF8, 32'h1234,     32'h0},         // R2 counter write
        '{1'b0, 16'hBFF8, 32'h0,        32'h0}          // R2 still zero
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [NH-1:0]     timer_irq;
    logic [NH-1:0]     soft_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_timer_unit #(.ADDR_W(ADDR_W), .NUM_HARTS(NH)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .timer_irq(timer_irq), .soft_irq(soft_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, "R8 rsp_valid", {31'b0, rsp_valid}, 32'h1);
        d = rsp_rdata;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R6: outputs low while in reset
        check(timer_irq == '0 && soft_irq == '0 && !rsp_valid, "R6 reset outputs",
              {28'b0, timer_irq, soft_irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R5: compare 0 <= counter 0 raises both timer lines
        check(timer_irq == 2'b11, "R5 zero compare", {30'b0, timer_irq}, 32'h3);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
                check(!rsp_valid, "R8 no rsp on write", {31'b0, rsp_valid}, 32'h0);
            end else begin
                bus_read(VECS[i].addr, rd);
                check(rd == VECS[i].exp, $sformatf("R3/R4/R6/R7 vec %0d", i), rd, VECS[i].exp);
            end
        end

        @(negedge clk);
        check(!rsp_valid, "R8 idle", {31'b0, rsp_valid}, 32'h0);
        check(soft_irq == 2'b10, "R3 soft line", {30'b0, soft_irq}, 32'h2);
        check(timer_irq == 2'b01, "R5 future compare", {30'b0, timer_irq}, 32'h1);

        // R2: high word after low read at zero
        bus_read(16'hBFFC, rd);
        check(rd == 32'h0, "R2 hi word", rd, 32'h0);

        // R1: 40 ticks
        ticks(40);
        bus_read(16'hBFF8, rd);
        check(rd == 32'd40, "R1 counter", rd, 32'd40);
        bus_read(16'hBFFC, rd);
        check(rd == 32'h0, "R2 snapshot hi", rd, 32'h0);
        bus_write(16'hBFFC, 32'hFFFF);
        bus_read(16'hBFF8, rd);
        check(rd == 32'd40, "R2 write ignored", rd, 32'd40);

        // R5: deadline 3 ahead on hart 0
        bus_write(16'h4000, 32'd43);
        check(timer_irq[0] == 1'b1, "R5 latency after write", {31'b0, timer_irq[0]}, 32'h1);
        @(negedge clk);
        check(timer_irq[0] == 1'b0, "R5 future lowers", {31'b0, timer_irq[0]}, 32'h0);
        ticks(2);
        @(negedge clk);
        check(timer_irq[0] == 1'b0, "R5 below deadline", {31'b0, timer_irq[0]}, 32'h0);
        ticks(1);
        check(timer_irq[0] == 1'b0, "R5 one-cycle latency", {31'b0, timer_irq[0]}, 32'h0);
        @(negedge clk);
        check(timer_irq[0] == 1'b1, "R5 reached deadline", {31'b0, timer_irq[0]}, 32'h1);

        // R4/R5: raising the high word pushes the deadline far out (unsigned)
        bus_write(16'h4004, 32'h8000_0000);
        @(negedge clk);
        check(timer_irq[0] == 1'b0, "R5 unsigned high", {31'b0, timer_irq[0]}, 32'h0);
        bus_read(16'h4000, rd);
        check(rd == 32'd43, "R4 hi write keeps lo", rd, 32'd43);
        // R3: clear soft line
        bus_write(16'h0004, 32'h0);
        check(soft_irq == 2'b00, "R3 clear", {30'b0, soft_irq}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule